// File: doc/BRIEF.md
# Banked Display RAM Write Address Generator

This block sits between a display controller's command decoder and a byte-wide display memory of 128 columns by 6 banks. Each bank covers 8 pixel rows, and the last bank holds icon bits. The block keeps a column pointer (X) and a bank pointer (Y). For every data byte it receives, it issues one memory write with an address, a per-bit write mask and the byte itself. It then moves the pointers on, stepping along columns (horizontal mode) or along banks (vertical mode).

Separate load strobes set X, Y and the addressing mode. A load value outside the legal range is refused, and the pointer keeps its old value. The icon bank stays outside the wrapping order. A write to the icon bank moves only X. The last graphic bank and the icon bank each accept only one bit position of the byte.

Top module: `dram_addr_gen`

## Requirements
- R1: After reset, X=0, Y=0 and horizontal mode are in effect, and `ram_we_o` is 0.
- R2: A high `wr_strobe_i` at a clock edge makes `ram_we_o` high for exactly the next cycle. In that cycle `ram_wdata_o` carries the byte, and `ram_addr_o` = {Y,X} holds the pointers as they were at the strobe, with Y in bits [9:7] and X in bits [6:0].
- R3: `set_x_i` loads X from `set_x_val_i` when the value is 127 or lower. A value of 128 or higher leaves X unchanged.
- R4: `set_y_i` loads Y from `set_y_val_i` when the value is 5 or lower. A value of 6 or 7 leaves Y unchanged.
- R5: In horizontal mode (`mode_vert_i`=0 loaded by `set_mode_i`), with Y in 0..4, each byte increments X. After X=127, X becomes 0 and Y increments.
- R6: In vertical mode (`mode_vert_i`=1), with Y in 0..4, each byte increments Y. After Y=4, Y becomes 0 and X increments.
- R7: After a byte written at X=127, Y=4, the pointers become X=0, Y=0 in either mode.
- R8: With Y=5, each byte increments X, wrapping 127 to 0, and Y stays 5 in either mode.
- R9: `ram_bit_en_o` is 8'hFF for banks 0..3, 8'h01 (bit 0 only) for bank 4, and 8'h10 (bit 4 only) for bank 5.
- R10: When a pointer load and a strobe share a cycle, the write uses the old pointers and the loaded value becomes the new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_strobe_i | input | 1 | One data byte present this cycle |
| wr_data_i | input | 8 | Data byte |
| set_x_i | input | 1 | Load column pointer |
| set_x_val_i | input | 8 | Column value to load |
| set_y_i | input | 1 | Load bank pointer |
| set_y_val_i | input | 3 | Bank value to load |
| set_mode_i | input | 1 | Load addressing mode |
| mode_vert_i | input | 1 | 1 = vertical, 0 = horizontal |
| ram_we_o | output | 1 | Memory write enable, one cycle per byte |
| ram_addr_o | output | 10 | Write address {bank, column} |
| ram_bit_en_o | output | 8 | Per-bit write enable |
| ram_wdata_o | output | 8 | Write data |

## Verification
The hardest situations to reach are the two corners of the address space: the final graphic address, where both pointers roll over together, and the icon bank, where the column wraps while the bank pointer stays put. Walking there by byte writes alone would take hundreds of bytes. The stimulus instead loads pointers next to each corner (column 126 or 127, bank 4 or 5) and then writes a short burst in each mode. A write and a load issued in the same cycle test the priority between the two updates.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic {
    ADV_HORIZ = 1'b0,
    ADV_VERT  = 1'b1
  } adv_mode_e;
endpackage

// File: rtl/dram_ptr_step.sv
module dram_ptr_step
  import dram_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int BANKS = 6,
  parameter int XW    = $clog2(COLS),
  parameter int YW    = $clog2(BANKS)
) (
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  input  adv_mode_e     mode_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);
  localparam logic [XW-1:0] XMAX = XW'(COLS - 1);
  localparam logic [YW-1:0] ICON = YW'(BANKS - 1);
  localparam logic [YW-1:0] YMAX = YW'(BANKS - 2);

  logic [XW-1:0] x_inc;
  logic          x_end;

  assign x_end = (x_i == XMAX);
  assign x_inc = x_end ? '0 : x_i + XW'(1);

  always_comb begin
    x_o = x_i;
    y_o = y_i;
    if (y_i == ICON) begin
      // icon bank: column only
      x_o = x_inc;
    end else if (mode_i == ADV_VERT) begin
      if (y_i == YMAX) begin
        y_o = '0;
        x_o = x_inc;
      end else begin
        y_o = y_i + YW'(1);
      end
    end else begin
      x_o = x_inc;
      if (x_end) y_o = (y_i == YMAX) ? '0 : y_i + YW'(1);
    end
  end
endmodule

// File: rtl/dram_bank_mask.sv
module dram_bank_mask #(
  parameter int BANKS    = 6,
  parameter int DW       = 8,
  parameter int EDGE_BIT = 0,
  parameter int ICON_BIT = 4,
  parameter int YW       = $clog2(BANKS)
) (
  input  logic [YW-1:0] y_i,
  output logic [DW-1:0] mask_o
);
  localparam logic [YW-1:0] ICON = YW'(BANKS - 1);
  localparam logic [YW-1:0] EDGE = YW'(BANKS - 2);

  logic is_icon, is_edge;
  assign is_icon = (y_i == ICON);
  assign is_edge = (y_i == EDGE);

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == EDGE_BIT) begin : g_edge
      assign mask_o[b] = !is_icon;
    end else if (b == ICON_BIT) begin : g_icon
      assign mask_o[b] = !is_edge;
    end else begin : g_full
      assign mask_o[b] = !is_icon && !is_edge;
    end
  end
endmodule

// File: rtl/dram_addr_gen.sv
module dram_addr_gen
  import dram_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int BANKS = 6,
  parameter int DW    = 8,
  parameter int XW    = $clog2(COLS),
  parameter int YW    = $clog2(BANKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_strobe_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            set_x_i,
  input  logic [XW:0]     set_x_val_i,
  input  logic            set_y_i,
  input  logic [YW-1:0]   set_y_val_i,
  input  logic            set_mode_i,
  input  logic            mode_vert_i,
  output logic            ram_we_o,
  output logic [YW+XW-1:0] ram_addr_o,
  output logic [DW-1:0]   ram_bit_en_o,
  output logic [DW-1:0]   ram_wdata_o
);
  localparam logic [XW:0]   XLIM = (XW+1)'(COLS);
  localparam logic [YW-1:0] YLIM = YW'(BANKS);
  localparam logic [YW-1:0] ICON = YW'(BANKS - 1);

  logic [XW-1:0] x_q, x_nx;
  logic [YW-1:0] y_q, y_nx;
  adv_mode_e     mode_q;
  logic [DW-1:0] mask;
  logic          x_ok, y_ok;

  assign x_ok = set_x_val_i < XLIM;
  assign y_ok = set_y_val_i < YLIM;

  dram_ptr_step #(.COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW)) i_step (
    .x_i(x_q), .y_i(y_q), .mode_i(mode_q), .x_o(x_nx), .y_o(y_nx)
  );

  dram_bank_mask #(.BANKS(BANKS), .DW(DW), .EDGE_BIT(0), .ICON_BIT(4), .YW(YW)) i_mask (
    .y_i(y_q), .mask_o(mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q          <= '0;
      y_q          <= '0;
      mode_q       <= ADV_HORIZ;
      ram_we_o     <= 1'b0;
      ram_addr_o   <= '0;
      ram_bit_en_o <= '0;
      ram_wdata_o  <= '0;
    end else begin
      ram_we_o <= wr_strobe_i;
      if (wr_strobe_i) begin
        ram_addr_o   <= {y_q, x_q};
        ram_bit_en_o <= mask;
        ram_wdata_o  <= wr_data_i;
      end
      // load beats advance
      if (set_x_i && x_ok)   x_q <= set_x_val_i[XW-1:0];
      else if (wr_strobe_i)  x_q <= x_nx;
      if (set_y_i && y_ok)   y_q <= set_y_val_i;
      else if (wr_strobe_i)  y_q <= y_nx;
      if (set_mode_i)        mode_q <= adv_mode_e'(mode_vert_i);
    end
  end

  // R2
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o == $past(wr_strobe_i));

  // R3
  bad_x_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_x_i && !x_ok && !wr_strobe_i) |=> $stable(x_q));

  // R4
  y_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_q < YLIM);

  // R8
  icon_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe_i && y_q == ICON && !set_y_i) |=> y_q == ICON);

  // R7
  final_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe_i && !set_x_i && !set_y_i && x_q == XW'(COLS-1) && y_q == YW'(BANKS-2))
    |=> (x_q == '0 && y_q == '0));

  // R9
  mask_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_bit_en_o != '0);
endmodule

// File: tb/test_dram_addr_gen.sv
module test_dram_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [7:0] data = '0;
  logic       setx = 1'b0, sety = 1'b0, setm = 1'b0, mvert = 1'b0;
  logic [7:0] xval = '0;
  logic [2:0] yval = '0;
  logic       ram_we;
  logic [9:0] ram_addr;
  logic [7:0] ram_mask, ram_wdata;

  int checks = 0, bad = 0;
  bit done = 1'b0;
  int mx = 0, my = 0;
  bit mv = 1'b0;

  logic [9:0] q_addr[$];
  logic [7:0] q_mask[$];
  logic [7:0] q_data[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_addr_gen i_dram_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_strobe_i(strobe), .wr_data_i(data),
    .set_x_i(setx), .set_x_val_i(xval), .set_y_i(sety), .set_y_val_i(yval),
    .set_mode_i(setm), .mode_vert_i(mvert), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_bit_en_o(ram_mask), .ram_wdata_o(ram_wdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mask(input int y);
    if (y < 4) return 8'hFF;
    if (y == 4) return 8'h01;
    return 8'h10;
  endfunction

  function automatic void model_step();
    if (my == 5) mx = (mx + 1) % 128;
    else if (mv) begin
      my++;
      if (my == 5) begin my = 0; mx = (mx + 1) % 128; end
    end else begin
      mx++;
      if (mx == 128) begin mx = 0; my = (my + 1) % 5; end
    end
  endfunction

  // monitor: scoreboard pop
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (q_addr.size() == 0) chk(1'b0, "R2 unexpected write", int'(ram_addr), 0);
      else begin
        logic [9:0] ea; logic [7:0] em, ed; string t;
        ea = q_addr.pop_front(); em = q_mask.pop_front();
        ed = q_data.pop_front(); t = q_tag.pop_front();
        chk(ram_addr == ea && ram_mask == em && ram_wdata == ed, t,
            int'({ram_addr, ram_mask, ram_wdata}), int'({ea, em, ed}));
      end
    end
  end

  task automatic push_exp(input logic [7:0] d, input string tag);
    q_addr.push_back({3'(my), 7'(mx)});
    q_mask.push_back(exp_mask(my));
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  task automatic wr_byte(input logic [7:0] d, input string tag);
    push_exp(d, tag);
    strobe = 1'b1; data = d;
    @(negedge clk);
    strobe = 1'b0;
    model_step();
  endtask

  task automatic load_x(input logic [7:0] v);
    setx = 1'b1; xval = v;
    @(negedge clk);
    setx = 1'b0;
    if (v < 128) mx = v;
  endtask

  task automatic load_y(input logic [2:0] v);
    sety = 1'b1; yval = v;
    @(negedge clk);
    sety = 1'b0;
    if (v < 6) my = v;
  endtask

  task automatic load_mode(input bit v);
    setm = 1'b1; mvert = v;
    @(negedge clk);
    setm = 1'b0;
    mv = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ram_we == 1'b0 && ram_addr == '0, "R1 reset outputs", int'({ram_we, ram_addr}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ram_we == 1'b0, "R1 idle after reset", int'(ram_we), 0);
    wr_byte(8'hA5, "R1 R2 first write at 0,0");
    // R5 horizontal
    for (int i = 0; i < 3; i++) wr_byte(8'(8'h10 + i), "R5 horizontal step");
    load_x(8'd126);
    for (int i = 0; i < 3; i++) wr_byte(8'(8'h20 + i), "R5 column wrap to next bank");
    // R3 rejected X
    load_x(8'd200);
    wr_byte(8'h33, "R3 out-of-range X ignored");
    load_x(8'd128);
    wr_byte(8'h34, "R3 X=128 ignored");
    load_x(8'd127);
    wr_byte(8'h35, "R3 X=127 accepted");
    // R4 rejected Y
    load_y(3'd7);
    wr_byte(8'h44, "R4 out-of-range Y ignored");
    load_y(3'd6);
    wr_byte(8'h45, "R4 Y=6 ignored");
    load_y(3'd3);
    wr_byte(8'h46, "R4 Y=3 accepted R9");
    // R7 horizontal final wrap, R9 edge bank mask
    load_y(3'd4); load_x(8'd127);
    wr_byte(8'h5A, "R7 R9 last graphic address");
    wr_byte(8'h5B, "R7 horizontal wrap to 0,0");
    // R6 vertical
    load_mode(1'b1);
    load_x(8'd5); load_y(3'd3);
    for (int i = 0; i < 4; i++) wr_byte(8'(8'h60 + i), "R6 vertical step");
    load_x(8'd127); load_y(3'd4);
    wr_byte(8'h70, "R7 vertical last address");
    wr_byte(8'h71, "R7 vertical wrap to 0,0");
    // R8 icon bank in both modes
    load_y(3'd5); load_x(8'd126);
    for (int i = 0; i < 3; i++) wr_byte(8'(8'h80 + i), "R8 R9 icon vertical");
    load_mode(1'b0);
    load_x(8'd127);
    for (int i = 0; i < 2; i++) wr_byte(8'(8'h90 + i), "R8 icon horizontal");
    // R10 load and strobe together
    load_y(3'd1); load_x(8'd10);
    push_exp(8'hC1, "R10 write uses old pointers");
    strobe = 1'b1; data = 8'hC1; setx = 1'b1; xval = 8'd40;
    @(negedge clk);
    strobe = 1'b0; setx = 1'b0;
    model_step(); mx = 40;
    wr_byte(8'hC2, "R10 loaded X wins");
    repeat (3) @(negedge clk);
    chk(q_addr.size() == 0, "R2 missing writes", q_addr.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule